// File: doc/BRIEF.md
# Indexed Codec Control Register File

This block is the control-register front end of an audio codec. A 32-bit, word-addressed bus reaches a 64-byte window that decodes into sixteen direct 32-bit words. Behind that window sits a bank of thirty-two byte-wide indirect registers. Software first writes an index into direct word 0, then reads or writes the selected indirect register through the data port at direct word 1.

Some indirect entries follow special rules. One is write-only. Two hold fixed version codes and cannot be written. One keeps a single writable bit next to a fixed codec version code. Direct word 2 cannot be written, and writing direct word 4 with its low bit set clears the whole block. The interrupt pin exists for the system to wire up but is never asserted here.

Top module: `codec_ctl_regs`

## Requirements
- R1: After hardware reset every direct word reads 0x00000000, read data is 0, and every indirect register reads zero except index 12 (0x8A) and index 25 (0xA0).
- R2: Byte address bits [5:2] select the direct word and address bits [1:0] have no effect; a written direct word (other than words 1, 2 and 4) reads back the full 32-bit value.
- R3: Read data is registered: it reflects a read request on the clock edge that follows the request and holds its value on cycles with no read request.
- R4: Direct word 0 stores all 32 written bits, and its bits [4:0] form the indirect index.
- R5: A write to word 1 stores data bits [7:0] into the indirect register at the current index, and a read of word 1 returns that register zero-extended to 32 bits.
- R6: A read of word 1 while the index is 3 returns zero.
- R7: Writes through word 1 while the index is 11 or 25 leave the register unchanged.
- R8: A write through word 1 while the index is 12 stores (data & 0x40) | 0x8A.
- R9: Writes to direct word 2 are ignored and it always reads zero.
- R10: A write to direct word 4 with data bit 0 set returns every register to its R1 value and then stores data & 0x7F in word 4; with bit 0 clear it only stores data & 0x7F.
- R11: The interrupt output stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Byte address within the window |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request, held low |

## Verification
The assertions assume that every request lasts one cycle, that `req_write` is only meaningful while `req_valid` is high, and that reset holds long enough to reach every register. The stimulus drives each request for one cycle at the falling edge and then drops `req_valid`. The random mix sets bit 0 of word-4 writes only rarely, so index and data state can build up between soft resets.

// File: rtl/codec_ctl_regs.sv
module codec_ctl_regs #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq
);
  localparam int WORD_W  = ADDR_W - 2;
  localparam int NUM_DIR = 2 ** WORD_W;
  localparam int NUM_IND = 2 ** IDX_W;

  localparam logic [WORD_W-1:0] W_INDEX = WORD_W'(0);
  localparam logic [WORD_W-1:0] W_DATA  = WORD_W'(1);
  localparam logic [WORD_W-1:0] W_LOCK  = WORD_W'(2);
  localparam logic [WORD_W-1:0] W_CTRL  = WORD_W'(4);

  localparam logic [IDX_W-1:0] I_WONLY = IDX_W'(3);
  localparam logic [IDX_W-1:0] I_RONLY = IDX_W'(11);
  localparam logic [IDX_W-1:0] I_CODEC = IDX_W'(12);
  localparam logic [IDX_W-1:0] I_CHIP  = IDX_W'(25);

  localparam logic [REG_W-1:0]  CODEC_CODE = REG_W'(8'h8A);
  localparam logic [REG_W-1:0]  CHIP_CODE  = REG_W'(8'hA0);
  localparam logic [REG_W-1:0]  CODEC_KEEP = REG_W'(8'h40);
  localparam logic [DATA_W-1:0] CTRL_MASK  = DATA_W'(32'h7F);

  logic [DATA_W-1:0] dreg [NUM_DIR];
  logic [REG_W-1:0]  ireg [NUM_IND];

  wire [WORD_W-1:0] word = req_addr[ADDR_W-1:2];
  wire [IDX_W-1:0]  idx  = dreg[W_INDEX][IDX_W-1:0];
  wire wr       = req_valid && req_write;
  wire rd       = req_valid && !req_write;
  wire soft_rst = wr && (word == W_CTRL) && req_wdata[0];
  wire ind_lock = (idx == I_RONLY) || (idx == I_CHIP);
  wire lane_unused = ^req_addr[1:0];

  function automatic logic [REG_W-1:0] ind_init(int i);
    if (i == int'(I_CODEC)) return CODEC_CODE;
    if (i == int'(I_CHIP))  return CHIP_CODE;
    return '0;
  endfunction

  assign irq = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_DIR; i++) dreg[i] <= '0;
      for (int i = 0; i < NUM_IND; i++) ireg[i] <= ind_init(i);
    end else if (soft_rst) begin
      for (int i = 0; i < NUM_DIR; i++) dreg[i] <= '0;
      for (int i = 0; i < NUM_IND; i++) ireg[i] <= ind_init(i);
      dreg[W_CTRL] <= req_wdata & CTRL_MASK;
    end else if (wr) begin
      if (word == W_DATA) begin
        if (idx == I_CODEC)
          ireg[idx] <= (req_wdata[REG_W-1:0] & CODEC_KEEP) | CODEC_CODE;
        else if (!ind_lock)
          ireg[idx] <= req_wdata[REG_W-1:0];
      end else if (word == W_CTRL) begin
        dreg[W_CTRL] <= req_wdata & CTRL_MASK;
      end else if (word != W_LOCK) begin
        dreg[word] <= req_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rsp_rdata <= '0;
    else if (rd) begin
      if (word == W_DATA)
        rsp_rdata <= (idx == I_WONLY) ? '0 : DATA_W'(ireg[idx]);
      else
        rsp_rdata <= dreg[word];
    end
  end

  assert_read_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rsp_rdata));

  assert_wonly_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd && word == W_DATA && idx == I_WONLY |=> rsp_rdata == '0);

  assert_ronly_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr && word == W_DATA && idx == I_RONLY |=> ireg[I_RONLY] == $past(ireg[I_RONLY]));

  assert_chip_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ireg[I_CHIP] == CHIP_CODE);

  assert_codec_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ireg[I_CODEC] & ~CODEC_KEEP) == CODEC_CODE);

  assert_lock_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd && word == W_LOCK |=> rsp_rdata == '0);

  assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> dreg[W_CTRL] == ($past(req_wdata) & CTRL_MASK) && dreg[W_INDEX] == '0);
endmodule

// File: tb/codec_ctl_regs_test.sv
module codec_ctl_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  logic [31:0] dmod [16];
  logic [7:0]  imod [32];

  codec_ctl_regs uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic model_reset();
    for (int i = 0; i < 16; i++) dmod[i] = '0;
    for (int i = 0; i < 32; i++) imod[i] = '0;
    imod[12] = 8'h8A;
    imod[25] = 8'hA0;
  endtask

  function automatic logic [31:0] model_read(logic [5:0] a);
    logic [3:0] w = a[5:2];
    logic [4:0] ix = dmod[0][4:0];
    if (w == 4'd1) return (ix == 5'd3) ? 32'h0 : {24'h0, imod[ix]};
    return dmod[w];
  endfunction

  task automatic model_write(logic [5:0] a, logic [31:0] d);
    logic [3:0] w = a[5:2];
    logic [4:0] ix = dmod[0][4:0];
    case (w)
      4'd1: begin
        if (ix == 5'd12) imod[ix] = (d[7:0] & 8'h40) | 8'h8A;
        else if (ix != 5'd11 && ix != 5'd25) imod[ix] = d[7:0];
      end
      4'd2: ;
      4'd4: begin
        if (d[0]) model_reset();
        dmod[4] = d & 32'h7F;
      end
      default: dmod[w] = d;
    endcase
  endtask

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_write(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    model_write(a, d);
  endtask

  task automatic do_read(logic [5:0] a, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, rsp_rdata, model_read(a));
    check("R11 irq", {31'h0, irq}, 32'h0);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog: got %0d cycles expected under 100000", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 rdata after reset", rsp_rdata, 32'h0);
    rst_n = 1'b1;

    for (int w = 0; w < 16; w++) do_read(6'(w * 4), "R1 direct reset");
    for (int i = 0; i < 32; i++) begin
      do_write(6'h00, 32'(i));
      do_read(6'h04, "R1 indirect reset");
    end

    do_write(6'h17, 32'hDEADBEEF);
    do_read(6'h14, "R2 low address bits ignored");
    do_read(6'h16, "R2 word readback");
    held = rsp_rdata;
    repeat (3) @(negedge clk);
    check("R3 read data holds", rsp_rdata, held);
    do_write(6'h20, 32'h12345678);
    check("R3 write leaves read data", rsp_rdata, held);

    do_write(6'h00, 32'hFFFF_FFE7);
    do_read(6'h00, "R4 index word full width");
    do_write(6'h04, 32'hAAAA_AA5C);
    do_read(6'h04, "R5 indirect write low byte");

    do_write(6'h00, 32'd3);
    do_write(6'h04, 32'h77);
    do_read(6'h04, "R6 write-only reads zero");
    do_write(6'h00, 32'd11);
    do_write(6'h04, 32'hFF);
    do_read(6'h04, "R7 index 11 locked");
    do_write(6'h00, 32'd25);
    do_write(6'h04, 32'h11);
    do_read(6'h04, "R7 index 25 locked");
    do_write(6'h00, 32'd12);
    do_write(6'h04, 32'hFF);
    do_read(6'h04, "R8 codec bit set");
    do_write(6'h04, 32'h00);
    do_read(6'h04, "R8 codec bit clear");

    do_write(6'h08, 32'hCAFEF00D);
    do_read(6'h08, "R9 word 2 ignored");

    do_write(6'h10, 32'hFFFF_FF7E);
    do_read(6'h10, "R10 mask without reset");
    do_read(6'h14, "R10 no reset on bit0 clear");
    do_write(6'h00, 32'd7);
    do_write(6'h04, 32'h5A);
    do_write(6'h10, 32'hFFFF_FFFF);
    do_read(6'h10, "R10 mask after soft reset");
    do_read(6'h14, "R10 direct cleared");
    do_read(6'h00, "R10 index cleared");
    do_write(6'h00, 32'd7);
    do_read(6'h04, "R10 indirect cleared");
    do_write(6'h00, 32'd12);
    do_read(6'h04, "R10 codec code restored");

    for (int n = 0; n < 600; n++) begin
      logic [3:0]  w;
      logic [31:0] d;
      w = ($urandom_range(0, 2) == 0) ? 4'($urandom_range(0, 15)) : 4'($urandom_range(0, 1));
      d = $urandom;
      if (w == 4'd4 && $urandom_range(0, 7) != 0) d[0] = 1'b0;
      if (w == 4'd0 && $urandom_range(0, 3) == 0) d[4:0] = 5'($urandom_range(0, 3)) == 0 ? 5'd3 : 5'd12;
      if ($urandom_range(0, 1) == 0)
        do_write({w, 2'($urandom_range(0, 3))}, d);
      else
        do_read({w, 2'($urandom_range(0, 3))}, "R5 random access");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule